// File: doc/BRIEF.md
# SIMD Word Insert Execution Unit

This unit is one registered pipeline step of a vector execution cluster. It writes one 16-bit word, taken from a scalar source, into a packed 256-bit vector value. It chooses the word slot from an 8-bit immediate. Every word it does not overwrite comes from a base vector. The encoding mode selects that base vector, sets how many immediate bits count, and sets what happens to the bits above the affected lane.

There are three encodings:

- **64-bit legacy form.** The destination is rewritten in place. Only the low 64 bits can change.
- **128-bit legacy form.** The destination is rewritten in place. Only the low 128 bits can change.
- **Three-operand vector form.** The base comes from a separate first-source vector, and the upper half of the result is cleared. In this form only, a vector-length bit of 1 marks an illegal encoding. The unit then raises an undefined-opcode fault instead of producing a result.

Decode, register renaming, memory operands and fault delivery live outside the unit. The unit only flags the fault. Results appear one clock after the operation strobe, together with a one-cycle result-valid pulse.

Top module: `wins_unit`

## Requirements
- R1: Only bits [15:0] of `scalar_src` are written into the result. Bits [31:16] of `scalar_src` never affect any output.
- R2: When `op_mode` is 2'b00 (64-bit legacy), the slot number is `imm[1:0]` and `imm[7:2]` have no effect.
- R3: When `op_mode` is 2'b01 (128-bit legacy) or has bit 1 set (three-operand form, codes 2'b10 and 2'b11), the slot number is `imm[2:0]` and `imm[7:3]` have no effect.
- R4: Slot n occupies result bits [16n+15:16n]. Every other word below the lane top (bit 64 or bit 128) equals the corresponding word of the base vector.
- R5: In the two legacy modes the base vector is `dst_vec`. In the three-operand form the base vector is `src1_vec`, and `dst_vec` has no effect on the result.
- R6: In 64-bit legacy mode, result bits [255:64] equal `dst_vec[255:64]`.
- R7: In 128-bit legacy mode, result bits [255:128] equal `dst_vec[255:128]`.
- R8: In the three-operand form with no fault, result bits [255:128] are zero.
- R9: In the three-operand form with `vlen` = 1, `ud_fault` is 1 alongside the result-valid pulse and `res_vec` keeps its previous value. In the legacy modes `vlen` has no effect.
- R10: `res_vld` is 1 exactly in the cycle after a cycle with `op_vld` = 1. `res_vec` changes only on such an edge. `ud_fault` is 1 only while `res_vld` is 1.
- R11: While `rst_n` is 0, `res_vld`, `ud_fault` and `res_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Operation strobe; one operation per cycle in which it is 1 |
| op_mode | input | 2 | Encoding: 00 = 64-bit legacy, 01 = 128-bit legacy, 1x = three-operand form |
| scalar_src | input | 32 | Scalar source; its low word is inserted |
| dst_vec | input | 256 | Current destination value (base vector in legacy modes) |
| src1_vec | input | 256 | First-source vector (base vector in the three-operand form) |
| imm | input | 8 | Immediate holding the slot number |
| vlen | input | 1 | Vector-length bit; must be 0 in the three-operand form |
| res_vld | output | 1 | One-cycle pulse marking a completed operation |
| res_vec | output | 256 | Registered result vector |
| ud_fault | output | 1 | Undefined-opcode fault for the completed operation |

## Verification
The hardest case to reach is a faulting operation that lands directly after a good result. Only that sequence shows whether the fault path really holds the previous result rather than a merged or cleared value. It also needs a three-operand encoding with the length bit set, and the random stream produces that in only a small share of operations.

The stimulus handles this in two ways. A directed pair issues a good three-operand operation and then a faulting one. The random stream weights the modes and the length bit so that faults follow good operations many times over. It also fills the unused immediate bits, the upper scalar word and whichever base vector is not selected with random data, so that any leak from them shows up as a mismatch.

// File: rtl/wins_pkg.sv
package wins_pkg;

  // Encoding modes; bit 1 set means the three-operand form
  typedef enum logic [1:0] {
    WM_LEG64  = 2'b00,
    WM_LEG128 = 2'b01,
    WM_VEC    = 2'b10,
    WM_VEC_B  = 2'b11
  } wins_mode_e;

  function automatic logic mode_is_three_op(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_wide(input logic [1:0] m);
    return (m != WM_LEG64);
  endfunction

endpackage

// File: rtl/wins_slot_dec.sv
module wins_slot_dec #(
  parameter int IMM_W    = 8,
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 64,
  parameter int WIDE_W   = 128,
  localparam int NWORDS  = WIDE_W / WORD_W,
  localparam int SLOT_W  = $clog2(NWORDS),
  localparam int NSLOT_N = NARROW_W / WORD_W,
  localparam int NBITS_N = $clog2(NSLOT_N)
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              wide,
  output logic [SLOT_W-1:0] slot,
  output logic [NWORDS-1:0] word_en,
  output logic [WIDE_W-1:0] mask
);

  // Narrow mode takes only the low immediate bits; the rest are dropped
  always_comb begin
    if (wide) slot = imm[SLOT_W-1:0];
    else      slot = {{(SLOT_W-NBITS_N){1'b0}}, imm[NBITS_N-1:0]};
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign word_en[w] = (slot == SLOT_W'(w));
    assign mask[w*WORD_W +: WORD_W] = {WORD_W{word_en[w]}};
  end

  // R2/R3: exactly one slot is chosen, and narrow mode never selects above the narrow lane
  always_comb begin
    if (!$isunknown(imm) && !$isunknown(wide)) begin
      assert_one_slot_R4: assert ($countones(word_en) == 1)
        else $error("slot decode not one-hot");
      assert_narrow_slot_R2: assert (wide || (mask[WIDE_W-1:NARROW_W] == '0))
        else $error("narrow slot outside lane");
    end
  end

endmodule

// File: rtl/wins_merge.sv
module wins_merge #(
  parameter int WORD_W  = 16,
  parameter int WIDE_W  = 128,
  localparam int SLOT_W = $clog2(WIDE_W / WORD_W)
) (
  input  logic [WIDE_W-1:0] base,
  input  logic [WORD_W-1:0] word,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WIDE_W-1:0] mask,
  output logic [WIDE_W-1:0] merged
);

  // Mask-and-merge: clear the slot, then OR in the shifted word
  function automatic logic [WIDE_W-1:0] put_word(
    input logic [WIDE_W-1:0] b,
    input logic [WORD_W-1:0] wd,
    input logic [SLOT_W-1:0] s,
    input logic [WIDE_W-1:0] m
  );
    logic [WIDE_W-1:0] shifted;
    shifted = WIDE_W'(wd) << (int'(s) * WORD_W);
    return (b & ~m) | (shifted & m);
  endfunction

  assign merged = put_word(base, word, slot, mask);

  // R4: bits outside the chosen slot are untouched
  always_comb begin
    if (!$isunknown(base) && !$isunknown(mask)) begin
      assert_outside_slot_R4: assert (((merged ^ base) & ~mask) == '0)
        else $error("merge touched bits outside slot");
    end
  end

endmodule

// File: rtl/wins_lane_mux.sv
module wins_lane_mux #(
  parameter int VEC_W  = 256,
  parameter int WIDE_W = 128
) (
  input  logic             three_op,
  input  logic [VEC_W-1:0] dst_vec,
  input  logic [VEC_W-1:0] src1_vec,
  input  logic [WIDE_W-1:0] merged_lo,
  output logic [WIDE_W-1:0] base_lo,
  output logic [VEC_W-1:0] next_vec
);

  localparam int UPPER_W = VEC_W - WIDE_W;

  logic [UPPER_W-1:0] upper;

  // R5: the three-operand form merges into src1, the legacy forms into dst
  assign base_lo = three_op ? src1_vec[WIDE_W-1:0] : dst_vec[WIDE_W-1:0];
  // R6/R7/R8: legacy keeps the upper bits, the three-operand form clears them
  assign upper    = three_op ? '0 : dst_vec[VEC_W-1:WIDE_W];
  assign next_vec = {upper, merged_lo};

endmodule

// File: rtl/wins_unit.sv
module wins_unit
  import wins_pkg::*;
#(
  parameter int VEC_W    = 256,
  parameter int WIDE_W   = 128,
  parameter int NARROW_W = 64,
  parameter int WORD_W   = 16,
  parameter int SCALAR_W = 32,
  parameter int IMM_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_vld,
  input  logic [1:0]          op_mode,
  input  logic [SCALAR_W-1:0] scalar_src,
  input  logic [VEC_W-1:0]    dst_vec,
  input  logic [VEC_W-1:0]    src1_vec,
  input  logic [IMM_W-1:0]    imm,
  input  logic                vlen,
  output logic                res_vld,
  output logic [VEC_W-1:0]    res_vec,
  output logic                ud_fault
);

  localparam int NWORDS = WIDE_W / WORD_W;
  localparam int SLOT_W = $clog2(NWORDS);

  // Named internal events
  logic              three_op;
  logic              wide;
  logic              len_bad;
  logic              upd_en;
  logic [SLOT_W-1:0] slot;
  logic [NWORDS-1:0] word_en;
  logic [WIDE_W-1:0] mask;
  logic [WIDE_W-1:0] base_lo;
  logic [WIDE_W-1:0] merged_lo;
  logic [VEC_W-1:0]  next_vec;
  logic [WORD_W-1:0] ins_word;

  assign three_op = mode_is_three_op(op_mode);
  assign wide     = mode_is_wide(op_mode);
  assign len_bad  = three_op & vlen;              // R9
  assign upd_en   = op_vld & ~len_bad;
  assign ins_word = scalar_src[WORD_W-1:0];       // R1

  wins_slot_dec #(
    .IMM_W(IMM_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
  ) u_dec (
    .imm(imm), .wide(wide), .slot(slot), .word_en(word_en), .mask(mask)
  );

  wins_lane_mux #(.VEC_W(VEC_W), .WIDE_W(WIDE_W)) u_lane (
    .three_op(three_op), .dst_vec(dst_vec), .src1_vec(src1_vec),
    .merged_lo(merged_lo), .base_lo(base_lo), .next_vec(next_vec)
  );

  wins_merge #(.WORD_W(WORD_W), .WIDE_W(WIDE_W)) u_merge (
    .base(base_lo), .word(ins_word), .slot(slot), .mask(mask), .merged(merged_lo)
  );

  // Output stage: one clock of latency (R10, R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      ud_fault <= 1'b0;
      res_vec  <= '0;
    end else begin
      res_vld  <= op_vld;
      ud_fault <= op_vld & len_bad;
      if (upd_en) res_vec <= next_vec;
    end
  end

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld == $past(op_vld && rst_n))
    else $error("result valid not one cycle after strobe");

  assert_fault_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> res_vld)
    else $error("fault without valid");

  assert_fault_holds_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && ud_fault) |-> $stable(res_vec))
    else $error("result changed on fault");

  assert_idle_holds_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> $stable(res_vec))
    else $error("result changed without strobe");

  assert_vec_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !ud_fault && $past(op_mode[1])) |-> (res_vec[VEC_W-1:WIDE_W] == '0))
    else $error("upper bits not cleared in three-operand form");

  assert_leg128_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(op_mode == 2'b01)) |->
      (res_vec[VEC_W-1:WIDE_W] == $past(dst_vec[VEC_W-1:WIDE_W])))
    else $error("upper bits not preserved in 128-bit legacy");

  assert_leg64_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(op_mode == 2'b00)) |->
      (res_vec[VEC_W-1:NARROW_W] == $past(dst_vec[VEC_W-1:NARROW_W])))
    else $error("upper bits not preserved in 64-bit legacy");

endmodule

// File: tb/wins_unit_tb.sv
`timescale 1ns/1ps
module wins_unit_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_vld = 1'b0;
  logic [1:0]   op_mode = 2'b00;
  logic [31:0]  scalar_src = '0;
  logic [255:0] dst_vec = '0;
  logic [255:0] src1_vec = '0;
  logic [7:0]   imm = '0;
  logic         vlen = 1'b0;
  logic         res_vld;
  logic [255:0] res_vec;
  logic         ud_fault;

  int n_chk = 0;
  int n_bad = 0;
  logic [255:0] model_res = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wins_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_mode(op_mode),
    .scalar_src(scalar_src), .dst_vec(dst_vec), .src1_vec(src1_vec),
    .imm(imm), .vlen(vlen), .res_vld(res_vld), .res_vec(res_vec),
    .ud_fault(ud_fault)
  );

  // Reference written word by word from the requirements
  function automatic logic [255:0] ref_insert(
    input logic [1:0] md, input logic [31:0] sc, input logic [255:0] d,
    input logic [255:0] s1, input logic [7:0] im
  );
    logic [255:0] r;
    int pos, top;
    if (md == 2'b00) begin pos = im % 4; top = 4; end
    else begin pos = im % 8; top = 8; end
    r = md[1] ? {128'h0, s1[127:0]} : d;
    for (int w = 0; w < top; w++)
      if (w == pos) r[w*16 +: 16] = sc[15:0];
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string tag, input logic [255:0] got_v,
                       input logic [255:0] exp_v, input logic gf, input logic ef,
                       input logic gv, input logic ev);
    n_chk++;
    if (got_v !== exp_v || gf !== ef || gv !== ev) begin
      n_bad++;
      $display("FAIL %s: got vec=%h flt=%b vld=%b exp vec=%h flt=%b vld=%b",
               tag, got_v, gf, gv, exp_v, ef, ev);
    end
  endtask

  // Drive one operation at a falling edge, check after the next rising edge
  task automatic issue(input string tag, input logic [1:0] md, input logic [31:0] sc,
                       input logic [255:0] d, input logic [255:0] s1,
                       input logic [7:0] im, input logic vl);
    logic flt;
    @(negedge clk);
    op_vld = 1'b1; op_mode = md; scalar_src = sc; dst_vec = d;
    src1_vec = s1; imm = im; vlen = vl;
    flt = md[1] & vl;
    if (!flt) model_res = ref_insert(md, sc, d, s1, im);
    @(negedge clk);
    op_vld = 1'b0;
    dst_vec = rnd256(); src1_vec = rnd256(); imm = 8'($urandom);
    check(tag, res_vec, model_res, ud_fault, flt, res_vld, 1'b1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no completion exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] d0, s0;
    dst_vec = rnd256(); src1_vec = rnd256();
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset", res_vec, '0, ud_fault, 1'b0, res_vld, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: upper scalar bits dropped
    issue("R1 low word", 2'b01, 32'hABCD_1234, rnd256(), rnd256(), 8'h02, 1'b0);
    // R2: imm 0xFF in 64-bit mode selects slot 3
    issue("R2 narrow slot high imm", 2'b00, 32'hFFFF_BEEF, rnd256(), rnd256(), 8'hFF, 1'b0);
    // R6: 64-bit mode keeps bits above 64 even for slot 0
    issue("R6 narrow upper kept", 2'b00, 32'h0000_5A5A, rnd256(), rnd256(), 8'h04, 1'b1);
    // R3: slot 7 in 128-bit legacy, high imm bits set
    issue("R3 wide slot 7", 2'b01, 32'h1111_C0DE, rnd256(), rnd256(), 8'hF7, 1'b0);
    // R7: 128-bit legacy with vlen set is not a fault
    issue("R7 leg128 upper kept", 2'b01, 32'h0, rnd256(), rnd256(), 8'h08, 1'b1);
    // R5/R8: three-operand form uses src1 and clears the top
    issue("R5 R8 three-op base", 2'b10, 32'h7777_8421, rnd256(), rnd256(), 8'h05, 1'b0);
    issue("R8 three-op code 11", 2'b11, 32'h0000_FFFF, rnd256(), rnd256(), 8'h0E, 1'b0);
    // R9: a fault right after a good result must hold it
    issue("R4 good before fault", 2'b10, 32'h0000_1357, rnd256(), rnd256(), 8'h01, 1'b0);
    issue("R9 fault holds", 2'b10, 32'h0000_2468, rnd256(), rnd256(), 8'h03, 1'b1);
    // R10: the valid pulse lasts one cycle and the result stays put
    @(negedge clk);
    check("R10 idle after pulse", res_vec, model_res, ud_fault, 1'b0, res_vld, 1'b0);

    // R4: walk every slot in each width
    for (int s = 0; s < 8; s++) begin
      d0 = rnd256(); s0 = rnd256();
      issue("R4 wide walk", 2'b01, $urandom, d0, s0, 8'(s), 1'b0);
      issue("R4 narrow walk", 2'b00, $urandom, d0, s0, 8'(s), 1'b0);
    end

    // Random mix; three-operand form with vlen weighted for faults
    for (int i = 0; i < 400; i++) begin
      logic [1:0] md;
      logic vl;
      md = 2'($urandom % 4);
      vl = ($urandom % 3) == 0;
      issue("R1 R2 R3 R5 R9 random", md, $urandom, rnd256(), rnd256(), 8'($urandom), vl);
      if (($urandom % 5) == 0) begin
        @(negedge clk);
        check("R10 random idle", res_vec, model_res, ud_fault, 1'b0, res_vld, 1'b0);
      end
    end

    // R11: reset in the middle of the run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 mid reset", res_vec, '0, ud_fault, 1'b0, res_vld, 1'b0);
    model_res = '0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule